// File: doc/BRIEF.md
# Wake Confirmation Controller

This controller decides whether a wake request seen on a serial receive line is genuine. While the chip sleeps, only a long-low break event or a dedicated wake-pin event can start a wake attempt. The attempt turns on the clock and receive-path enables and waits for the receiver to report ready. It then listens, without transmitting, for a composite pattern: the line returning high for a delimiter period, followed by a programmable token of one to four bytes. The token must complete inside a bounded confirmation window, and the bus must be quiet, before the controller reports the link active.

Every failure rolls back to a sleep-arming state and then to sleep, so noise can never leave the chip awake and active. Idle-gap events are used only to start the return to sleep and never cause a wake. Four saturating counters record wake attempts, rollbacks, confirmed entries and window timeouts. A source code records which event began the most recent attempt. The line decoder and the byte receiver sit outside this block and deliver single-cycle event pulses to it.

Top module: `wake_confirm_fsm`

## Requirements
- R1: From sleep, only a break or wake-pin pulse starts an attempt, and it moves to wake-detect on the next clock edge. Idle and byte pulses in sleep have no effect. Each attempt adds one to the wake counter. The clock and receive enables are low in sleep and high in every other state.
- R2: Wake-detect holds, with no transmission, until receiver-ready is high, and then moves to confirm-listen.
- R3: In confirm-listen, a byte counts toward the token only after the line has been sampled high for DELIM_CYC consecutive cycles. A byte that arrives earlier is invalid and causes an immediate rollback.
- R4: Token byte i is held at token_i[8i+7:8i], and token_len_i (1 to TOK_MAX) gives the token length. A mismatched byte restarts matching; if that byte equals token byte 0, it counts as the first byte of the new match.
- R5: Active is entered from confirm-listen only after the full token has matched and bus_quiet_i has been high for QUIET_CYC consecutive cycles inside the window. Each such entry adds one to the active-entry counter.
- R6: If the link is not active after CONFIRM_CYC cycles in confirm-listen, the controller moves to sleep-arming. The timeout counter and the false-wake counter each gain one, and active is never asserted. Any rollback (timeout or invalid byte) adds one to the false-wake counter.
- R7: Active moves to sleep-arming on an idle pulse while work_pending_i is low. An idle pulse while work is pending is ignored.
- R8: In sleep-arming entered from active, a byte pulse returns the controller to active and leaves the active-entry counter unchanged. After a rollback, byte pulses are ignored. Sleep is entered only once SLEEP_CYC cycles have passed in sleep-arming with work_pending_i low and bus_quiet_i high.
- R9: Each counter is CNT_W bits wide, steps by one, and holds at all ones instead of wrapping.
- R10: The source code is 0 after reset, 1 when a break started the attempt (break wins if both arrive together), and 2 for the wake pin. It holds until the next attempt.
- R11: The state output encodes sleep 0, wake-detect 1, confirm-listen 2, active 3, sleep-arming 4. Active is high only in state 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_break_i | input | 1 | Break detected (one-cycle pulse) |
| evt_wake_pin_i | input | 1 | Dedicated wake pin event (pulse) |
| evt_idle_i | input | 1 | Idle window reached (pulse) |
| evt_byte_i | input | 1 | Received byte valid (pulse) |
| byte_i | input | 8 | Received byte value |
| rx_level_i | input | 1 | Synchronised receive line level |
| rx_ready_i | input | 1 | Receiver clocks and sampling ready |
| bus_quiet_i | input | 1 | No traffic on the bus |
| work_pending_i | input | 1 | Local work or transmission pending |
| token_i | input | TOK_MAX*8 | Confirmation token bytes, byte 0 lowest |
| token_len_i | input | LEN_W | Token length in bytes |
| clk_en_o | output | 1 | Clock enable request |
| rx_en_o | output | 1 | Receive path enable |
| state_o | output | 3 | Current state code |
| active_o | output | 1 | Link confirmed active |
| src_o | output | 2 | Source of the last attempt |
| wake_cnt_o | output | CNT_W | Wake attempts |
| false_wake_cnt_o | output | CNT_W | Rollbacks from confirm-listen |
| active_entry_cnt_o | output | CNT_W | Confirmed entries to active |
| timeout_cnt_o | output | CNT_W | Confirmation window timeouts |

## Verification
The properties assume that event inputs are pulses that are meaningful only in the states that consume them. They also assume that receiver-ready stays high from the moment it rises until the controller is back in sleep, and that bus-quiet describes the bus truthfully. The stimulus drives every event as a single-cycle pulse on the falling edge and holds receiver-ready from the first ready until sleep is reached. Bus-quiet is lowered only in the test that checks how it delays active entry.

// File: rtl/wake_pkg.sv
// Shared types for the wake confirmation controller.
// Assumes: state codes are visible at the top ports and must stay fixed.
package wake_pkg;
    typedef enum logic [2:0] {
        ST_SLEEP   = 3'd0,
        ST_WAKE    = 3'd1,
        ST_CONFIRM = 3'd2,
        ST_ACTIVE  = 3'd3,
        ST_ARM     = 3'd4
    } wk_state_e;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_BREAK = 2'd1,
        SRC_PIN   = 2'd2
    } wk_src_e;

    localparam int N_CNT      = 4;
    localparam int CNT_WAKE   = 0;
    localparam int CNT_FALSE  = 1;
    localparam int CNT_ACTIVE = 2;
    localparam int CNT_TMO    = 3;
endpackage

// File: rtl/wk_sat_counter.sv
// Saturating event counter: steps by one per inc pulse, holds at all ones.
// Assumes: inc_i is a single-cycle qualified pulse.
module wk_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_q;

    // Count events, stopping at the maximum code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (inc_i && (cnt_q != {W{1'b1}}))
            cnt_q <= cnt_q + W'(1);
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/wk_down_timer.sv
// Loadable down-counter; done_o is high while the count is zero.
// Assumes: the caller loads value-1 to obtain a window of value cycles.
module wk_down_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    input  logic         run_i,
    output logic         done_o
);
    logic [W-1:0] cnt_q;

    // Load on request, otherwise decrement while running until zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= value_i;
        else if (run_i && (cnt_q != '0))
            cnt_q <= cnt_q - W'(1);
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/wk_token_match.sv
// Sequential byte matcher for the confirmation token.
// A mismatched byte restarts matching; if it equals token byte 0 it becomes
// the first byte of the new attempt. hit_o is sticky until clr_i.
// Assumes: len_i lies in 1..TOK_MAX while vld_i pulses arrive.
module wk_token_match #(
    parameter int TOK_MAX = 4,
    parameter int LEN_W   = $clog2(TOK_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 vld_i,
    input  logic [7:0]           byte_i,
    input  logic [TOK_MAX*8-1:0] token_i,
    input  logic [LEN_W-1:0]     len_i,
    output logic                 hit_o
);
    localparam int IDX_W = (TOK_MAX > 1) ? $clog2(TOK_MAX) : 1;

    logic [7:0]       tok_b [TOK_MAX];
    logic [IDX_W-1:0] idx_q;
    logic             hit_q;
    logic             last_pos;

    // Unpack the flat token port into bytes.
    always_comb begin
        for (int i = 0; i < TOK_MAX; i++)
            tok_b[i] = token_i[i*8 +: 8];
    end

    assign last_pos = ((LEN_W'(idx_q) + LEN_W'(1)) >= len_i);

    // Advance, restart or complete the match on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            idx_q <= '0;
            hit_q <= 1'b0;
        end else if (vld_i && !hit_q) begin
            if (byte_i == tok_b[idx_q]) begin
                if (last_pos) hit_q <= 1'b1;
                else          idx_q <= idx_q + IDX_W'(1);
            end else if (byte_i == tok_b[0]) begin
                if (len_i <= LEN_W'(1)) hit_q <= 1'b1;
                else                    idx_q <= IDX_W'(1);
            end else begin
                idx_q <= '0;
            end
        end
    end

    assign hit_o = hit_q;
endmodule

// File: rtl/wake_confirm_fsm.sv
// Wake confirmation controller: sleep -> wake-detect -> confirm-listen ->
// active -> sleep-arming, with deterministic rollback on any failure.
// Assumes: events are single-cycle pulses from an upstream line decoder;
// rx_level_i is already synchronised to clk.
module wake_confirm_fsm
    import wake_pkg::*;
#(
    parameter int TOK_MAX     = 4,
    parameter int DELIM_CYC   = 8,
    parameter int QUIET_CYC   = 16,
    parameter int CONFIRM_CYC = 4096,
    parameter int SLEEP_CYC   = 1024,
    parameter int CNT_W       = 8,
    parameter int LEN_W       = $clog2(TOK_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_break_i,
    input  logic                 evt_wake_pin_i,
    input  logic                 evt_idle_i,
    input  logic                 evt_byte_i,
    input  logic [7:0]           byte_i,
    input  logic                 rx_level_i,
    input  logic                 rx_ready_i,
    input  logic                 bus_quiet_i,
    input  logic                 work_pending_i,
    input  logic [TOK_MAX*8-1:0] token_i,
    input  logic [LEN_W-1:0]     token_len_i,
    output logic                 clk_en_o,
    output logic                 rx_en_o,
    output logic [2:0]           state_o,
    output logic                 active_o,
    output logic [1:0]           src_o,
    output logic [CNT_W-1:0]     wake_cnt_o,
    output logic [CNT_W-1:0]     false_wake_cnt_o,
    output logic [CNT_W-1:0]     active_entry_cnt_o,
    output logic [CNT_W-1:0]     timeout_cnt_o
);
    localparam int DW  = $clog2(DELIM_CYC + 1);
    localparam int QW  = $clog2(QUIET_CYC + 1);
    localparam int CTW = $clog2(CONFIRM_CYC + 1);
    localparam int STW = $clog2(SLEEP_CYC + 1);

    wk_state_e        st_q, st_d;
    wk_src_e          src_q;
    logic [DW-1:0]    delim_cnt_q;
    logic             delim_ok_q;
    logic [QW-1:0]    quiet_cnt_q;
    logic             quiet_ok;
    logic             from_active_q;
    logic             tok_hit, win_done, slp_done;
    logic             in_confirm, start_confirm, bad_byte, go_active;
    logic             enter_arm;
    logic [N_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0] cnt_val [N_CNT];

    assign in_confirm    = (st_q == ST_CONFIRM);
    assign start_confirm = (st_q == ST_WAKE) && rx_ready_i;
    assign bad_byte      = in_confirm && evt_byte_i && !delim_ok_q;
    assign quiet_ok      = (quiet_cnt_q == QW'(QUIET_CYC));
    assign go_active     = in_confirm && !bad_byte && tok_hit && quiet_ok;
    assign enter_arm     = (st_d == ST_ARM) && (st_q != ST_ARM);

    // Next-state selection for the wake sequence.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_SLEEP:   if (evt_break_i || evt_wake_pin_i) st_d = ST_WAKE;
            ST_WAKE:    if (rx_ready_i) st_d = ST_CONFIRM;
            ST_CONFIRM: begin
                if (bad_byte)       st_d = ST_ARM;
                else if (go_active) st_d = ST_ACTIVE;
                else if (win_done)  st_d = ST_ARM;
            end
            ST_ACTIVE:  if (evt_idle_i && !work_pending_i) st_d = ST_ARM;
            ST_ARM: begin
                if (from_active_q && evt_byte_i)
                    st_d = ST_ACTIVE;
                else if (slp_done && !work_pending_i && bus_quiet_i)
                    st_d = ST_SLEEP;
            end
            default:    st_d = ST_SLEEP;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_SLEEP;
        else        st_q <= st_d;
    end

    // Remember whether sleep-arming was reached from a confirmed link.
    always_ff @(posedge clk) begin
        if (!rst_n)
            from_active_q <= 1'b0;
        else if (enter_arm)
            from_active_q <= (st_q == ST_ACTIVE);
    end

    // Record which event started the latest wake attempt.
    always_ff @(posedge clk) begin
        if (!rst_n)
            src_q <= SRC_NONE;
        else if (st_q == ST_SLEEP && (evt_break_i || evt_wake_pin_i))
            src_q <= evt_break_i ? SRC_BREAK : SRC_PIN;
    end

    // Measure the high delimiter that must precede the token.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_confirm) begin
            delim_cnt_q <= '0;
            delim_ok_q  <= 1'b0;
        end else if (!rx_level_i) begin
            delim_cnt_q <= '0;
        end else if (!delim_ok_q) begin
            delim_cnt_q <= delim_cnt_q + DW'(1);
            if (delim_cnt_q == DW'(DELIM_CYC - 1))
                delim_ok_q <= 1'b1;
        end
    end

    // Count consecutive bus-quiet cycles inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_confirm || !bus_quiet_i)
            quiet_cnt_q <= '0;
        else if (!quiet_ok)
            quiet_cnt_q <= quiet_cnt_q + QW'(1);
    end

    wk_token_match #(
        .TOK_MAX (TOK_MAX),
        .LEN_W   (LEN_W)
    ) i_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (start_confirm),
        .vld_i   (in_confirm && evt_byte_i && delim_ok_q),
        .byte_i  (byte_i),
        .token_i (token_i),
        .len_i   (token_len_i),
        .hit_o   (tok_hit)
    );

    wk_down_timer #(.W(CTW)) i_win_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start_confirm),
        .value_i (CTW'(CONFIRM_CYC - 1)),
        .run_i   (in_confirm),
        .done_o  (win_done)
    );

    wk_down_timer #(.W(STW)) i_slp_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (enter_arm),
        .value_i (STW'(SLEEP_CYC - 1)),
        .run_i   (st_q == ST_ARM),
        .done_o  (slp_done)
    );

    // Counter increment strobes derived from the taken transitions.
    always_comb begin
        cnt_inc             = '0;
        cnt_inc[CNT_WAKE]   = (st_q == ST_SLEEP) && (st_d == ST_WAKE);
        cnt_inc[CNT_FALSE]  = in_confirm && (st_d == ST_ARM);
        cnt_inc[CNT_ACTIVE] = in_confirm && (st_d == ST_ACTIVE);
        cnt_inc[CNT_TMO]    = in_confirm && (st_d == ST_ARM) && !bad_byte;
    end

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        wk_sat_counter #(.W(CNT_W)) i_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc_i (cnt_inc[g]),
            .cnt_o (cnt_val[g])
        );
    end

    assign clk_en_o           = (st_q != ST_SLEEP);
    assign rx_en_o            = (st_q != ST_SLEEP);
    assign state_o            = st_q;
    assign active_o           = (st_q == ST_ACTIVE);
    assign src_o              = src_q;
    assign wake_cnt_o         = cnt_val[CNT_WAKE];
    assign false_wake_cnt_o   = cnt_val[CNT_FALSE];
    assign active_entry_cnt_o = cnt_val[CNT_ACTIVE];
    assign timeout_cnt_o      = cnt_val[CNT_TMO];
endmodule

// File: rtl/wk_fsm_checker.sv
// Temporal properties of the wake confirmation controller, bound to its top.
// Assumes: events are pulses; rx_ready_i stays high until sleep is reached.
module wk_fsm_checker
    import wake_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt_break_i,
    input logic             evt_wake_pin_i,
    input logic             rx_ready_i,
    input logic             bus_quiet_i,
    input logic             work_pending_i,
    input logic             clk_en_o,
    input logic [2:0]       state_o,
    input logic [CNT_W-1:0] wake_cnt_o,
    input logic [CNT_W-1:0] false_wake_cnt_o,
    input logic [CNT_W-1:0] active_entry_cnt_o
);
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    assert_sleep_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_SLEEP && !evt_break_i && !evt_wake_pin_i) |=> (state_o == ST_SLEEP));

    assert_clk_en_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en_o) |-> $past(evt_break_i || evt_wake_pin_i));

    assert_wait_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_WAKE && !rx_ready_i) |=> (state_o == ST_WAKE));

    assert_quiet_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_ACTIVE && $past(state_o) == ST_CONFIRM) |-> $past(bus_quiet_i));

    assert_entry_counted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_ACTIVE && $past(state_o) == ST_CONFIRM)
        |-> (active_entry_cnt_o != $past(active_entry_cnt_o) || $past(active_entry_cnt_o) == FULL));

    assert_rollback_counted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_ARM && $past(state_o) == ST_CONFIRM)
        |-> (false_wake_cnt_o != $past(false_wake_cnt_o) || $past(false_wake_cnt_o) == FULL));

    assert_pending_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_ACTIVE && work_pending_i) |=> (state_o == ST_ACTIVE));

    assert_sleep_via_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_SLEEP && $past(state_o) != ST_SLEEP) |-> ($past(state_o) == ST_ARM));

    assert_wake_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_cnt_o != $past(wake_cnt_o)) |-> (wake_cnt_o == $past(wake_cnt_o) + CNT_W'(1)));

    assert_wake_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wake_cnt_o) == FULL) |-> (wake_cnt_o == FULL));
endmodule

bind wake_confirm_fsm wk_fsm_checker #(.CNT_W(CNT_W)) i_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .evt_break_i        (evt_break_i),
    .evt_wake_pin_i     (evt_wake_pin_i),
    .rx_ready_i         (rx_ready_i),
    .bus_quiet_i        (bus_quiet_i),
    .work_pending_i     (work_pending_i),
    .clk_en_o           (clk_en_o),
    .state_o            (state_o),
    .wake_cnt_o         (wake_cnt_o),
    .false_wake_cnt_o   (false_wake_cnt_o),
    .active_entry_cnt_o (active_entry_cnt_o)
);

// File: tb/test_wake_confirm_fsm.sv
module test_wake_confirm_fsm;
    localparam int TOK_MAX = 4;
    localparam int DELIM   = 4;
    localparam int QUIET   = 3;
    localparam int CONFIRM = 40;
    localparam int SLPC    = 10;
    localparam int CW      = 3;
    localparam int LW      = 3;

    typedef struct packed {
        logic [1:0]  src;
        logic [3:0]  ndelim;
        logic [2:0]  nbytes;
        logic [31:0] bytes;
        logic        exp_act;
        logic        exp_to;
    } vec_t;

    // Scenario table: source, delimiter length, bytes sent, expected outcome.
    localparam vec_t VECS [5] = '{
        '{2'd1, 4'd6, 3'd3, 32'h000F3CA5, 1'b1, 1'b0},
        '{2'd2, 4'd6, 3'd3, 32'h000F3CA5, 1'b1, 1'b0},
        '{2'd1, 4'd6, 3'd4, 32'h0F3CA5A5, 1'b1, 1'b0},
        '{2'd1, 4'd6, 3'd2, 32'h00000F3C, 1'b0, 1'b1},
        '{2'd2, 4'd1, 3'd1, 32'h000000A5, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_break = 0, evt_pin = 0, evt_idle = 0, evt_byte = 0;
    logic [7:0] rx_byte = '0;
    logic rx_level = 1'b0, rx_ready = 1'b0, bus_quiet = 1'b1, work_pending = 1'b0;
    logic clk_en, rx_en, active;
    logic [2:0] state;
    logic [1:0] src;
    logic [CW-1:0] c_wake, c_false, c_act, c_to;

    int checks = 0;
    int fails  = 0;
    int m_wake = 0, m_false = 0, m_act = 0, m_to = 0;

    always #10 clk = ~clk;

    wake_confirm_fsm #(
        .TOK_MAX(TOK_MAX), .DELIM_CYC(DELIM), .QUIET_CYC(QUIET),
        .CONFIRM_CYC(CONFIRM), .SLEEP_CYC(SLPC), .CNT_W(CW)
    ) i_wake_confirm_fsm (
        .clk(clk), .rst_n(rst_n),
        .evt_break_i(evt_break), .evt_wake_pin_i(evt_pin),
        .evt_idle_i(evt_idle), .evt_byte_i(evt_byte), .byte_i(rx_byte),
        .rx_level_i(rx_level), .rx_ready_i(rx_ready), .bus_quiet_i(bus_quiet),
        .work_pending_i(work_pending),
        .token_i(32'h000F3CA5), .token_len_i(LW'(3)),
        .clk_en_o(clk_en), .rx_en_o(rx_en), .state_o(state), .active_o(active),
        .src_o(src), .wake_cnt_o(c_wake), .false_wake_cnt_o(c_false),
        .active_entry_cnt_o(c_act), .timeout_cnt_o(c_to)
    );

    function automatic int sat(int v);
        return (v >= (1 << CW) - 1) ? (1 << CW) - 1 : v + 1;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_counters(string req);
        check({req, " wake count"}, int'(c_wake), m_wake);
        check({req, " false count"}, int'(c_false), m_false);
        check({req, " active count"}, int'(c_act), m_act);
        check({req, " timeout count"}, int'(c_to), m_to);
    endtask

    task automatic wait_state(int s, int maxc, string req);
        for (int i = 0; i < maxc && int'(state) != s; i++) tick(1);
        check(req, int'(state), s);
    endtask

    task automatic pulse_byte(logic [7:0] b);
        rx_byte = b; evt_byte = 1'b1; tick(1);
        evt_byte = 1'b0; tick(1);
    endtask

    // Start an attempt and bring it to confirm-listen.
    task automatic wake_up(int use_pin);
        rx_level = 1'b0;
        if (use_pin != 0) evt_pin = 1'b1; else evt_break = 1'b1;
        tick(1);
        evt_pin = 1'b0; evt_break = 1'b0;
        m_wake = sat(m_wake);
        check("R1 wake-detect entered", int'(state), 1);
        check("R1 clock enable", int'(clk_en), 1);
        check("R1 receive enable", int'(rx_en), 1);
        tick(2);
        check("R2 waits for ready", int'(state), 1);
        rx_ready = 1'b1; tick(1);
        check("R2 confirm entered", int'(state), 2);
    endtask

    task automatic back_to_sleep(string req);
        wait_state(0, 80, req);
        rx_ready = 1'b0;
    endtask

    task automatic run_vec(vec_t v);
        wake_up(v.src == 2'd2 ? 1 : 0);
        check("R10 source code", int'(src), int'(v.src));
        rx_level = 1'b1; tick(int'(v.ndelim));
        for (int i = 0; i < int'(v.nbytes); i++) pulse_byte(v.bytes[i*8 +: 8]);
        tick(QUIET + 3);
        check("R4 R5 token outcome", int'(active), int'(v.exp_act));
        if (v.exp_act) begin
            m_act = sat(m_act);
            check("R11 active state code", int'(state), 3);
            evt_idle = 1'b1; tick(1); evt_idle = 1'b0;
            check("R7 idle arms sleep", int'(state), 4);
        end else begin
            m_false = sat(m_false);
            if (v.exp_to) m_to = sat(m_to);
            else check("R3 early byte rolls back", int'(state), 4);
        end
        back_to_sleep("R8 reaches sleep");
        check_counters("R9 table");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        tick(3);
        check("R11 reset state", int'(state), 0);
        check("R1 reset clock enable", int'(clk_en), 0);
        check("R10 reset source", int'(src), 0);
        check("R11 reset active", int'(active), 0);
        rst_n = 1'b1;
        tick(1);
        check_counters("R9 reset");

        // R1: idle and byte pulses in sleep have no effect.
        evt_idle = 1'b1; tick(1); evt_idle = 1'b0;
        pulse_byte(8'hA5);
        check("R1 idle ignored in sleep", int'(state), 0);
        check("R1 no wake counted", int'(c_wake), 0);

        for (int v = 0; v < 5; v++) run_vec(VECS[v]);

        // R7/R8: pending work, traffic resume and sleep gating.
        wake_up(0);
        rx_level = 1'b1; tick(6);
        pulse_byte(8'hA5); pulse_byte(8'h3C); pulse_byte(8'h0F);
        tick(QUIET + 3);
        m_act = sat(m_act);
        check("R5 active entry", int'(active), 1);
        work_pending = 1'b1;
        evt_idle = 1'b1; tick(1); evt_idle = 1'b0;
        check("R7 pending blocks arming", int'(state), 3);
        work_pending = 1'b0;
        evt_idle = 1'b1; tick(1); evt_idle = 1'b0;
        check("R7 arming", int'(state), 4);
        pulse_byte(8'h55);
        check("R8 traffic resumes active", int'(state), 3);
        check("R8 resume not counted", int'(c_act), m_act);
        evt_idle = 1'b1; tick(1); evt_idle = 1'b0;
        work_pending = 1'b1; tick(SLPC + 5);
        check("R8 pending holds arming", int'(state), 4);
        work_pending = 1'b0;
        back_to_sleep("R8 sleep after pending clears");

        // R5: token matched but bus busy delays entry by QUIET cycles.
        wake_up(1);
        bus_quiet = 1'b0;
        rx_level = 1'b1; tick(6);
        pulse_byte(8'hA5); pulse_byte(8'h3C); pulse_byte(8'h0F);
        tick(4);
        check("R5 busy bus blocks entry", int'(state), 2);
        bus_quiet = 1'b1; tick(QUIET);
        check("R5 still waiting on quiet", int'(state), 2);
        tick(1);
        m_act = sat(m_act);
        check("R5 entry after quiet run", int'(state), 3);
        evt_idle = 1'b1; tick(1); evt_idle = 1'b0;
        back_to_sleep("R8 sleep after quiet test");
        check_counters("R9 directed");

        // R6: exact window length, then bytes after rollback are ignored.
        wake_up(0);
        tick(CONFIRM - 1);
        check("R6 still in window", int'(state), 2);
        tick(1);
        m_false = sat(m_false); m_to = sat(m_to);
        check("R6 timeout rollback", int'(state), 4);
        check("R6 active never set", int'(active), 0);
        pulse_byte(8'hA5);
        check("R8 byte ignored after rollback", int'(state), 4);
        back_to_sleep("R8 sleep after rollback");

        // R9: drive counters into saturation.
        for (int k = 0; k < 5; k++) begin
            wake_up(1);
            m_false = sat(m_false); m_to = sat(m_to);
            back_to_sleep("R6 timeout loop");
        end
        check_counters("R9 saturation");
        check("R9 wake held at max", int'(c_wake), 7);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule